// File: doc/BRIEF.md
# Dual Master-Slave JK Flip-Flop Emulator

This block models two independent master-slave JK flip-flops inside an ordinary synchronous design. Each channel has a slow "device clock" input, J and K steering inputs, and active-low preset and clear inputs. The block samples all of these with a fast system clock, so it contains no latches and no logic clocked by a data signal. A two-stage synchronizer brings each input into the system clock domain. An edge detector then finds where the device clock goes from high to low.

While a channel's synchronized device clock is high, its master stage collects requests. A J or K seen high at any sample is held until the falling edge. A preset or clear pulse is held in the same way. At the falling edge the slave stage takes the new state from the master, and the master then empties. While the device clock is low, J and K are ignored. During that phase preset and clear act on the output directly, with no device-clock edge needed. There is no streaming data path, so the block has no valid/ready handshake. Every pin is a plain level that the system clock samples on each cycle.

Top module: `dual_msjk_top`

## Requirements
- R1: After the global reset `rst_n` is released, every channel shows `q`=0, `q_n`=1 and `conflict`=0. The global reset is the only thing that clears `conflict`.
- R2: `q_n` is always the exact bitwise complement of `q`.
- R3: An input change that is present at system edge E0 can affect `q` at system edge E0+2 at the earliest. While the synchronized device clock is high, `q` holds its value.
- R4: At a falling edge with no preset or clear request, the steering captured in the master decides the new `q`: J only gives 1, K only gives 0, J and K together give the complement of `q`, and neither leaves `q` unchanged.
- R5: J and K applied only while the device clock is low have no effect on `q`, either then or at the next falling edge.
- R6: A J or K seen high at any single system sample during the high phase is kept until the falling edge, even if the input drops again before the edge.
- R7: While the synchronized device clock is low, an active `set_n` forces `q`=1 and an active `clr_n` forces `q`=0, with no device-clock edge needed.
- R8: A `set_n` or `clr_n` pulse during the high phase leaves `q` unchanged during that phase. It loads the master, and `q` takes the loaded value at the following falling edge. A loaded preset or clear takes priority over J/K steering.
- R9: If `set_n` and `clr_n` are active together, clear wins and the channel's `conflict` flag goes high and stays high.
- R10: The channels are fully independent. Activity on one channel never changes `q`, `q_n` or `conflict` of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. It must be much faster than any device clock. |
| rst_n | input | 1 | Global asynchronous reset, active low |
| dev_clk | input | CHANNELS | Per-channel device clock. A falling edge transfers the master to the output. |
| j_in | input | CHANNELS | Per-channel J steering input |
| k_in | input | CHANNELS | Per-channel K steering input |
| set_n | input | CHANNELS | Per-channel preset, active low |
| clr_n | input | CHANNELS | Per-channel clear, active low |
| q | output | CHANNELS | Per-channel flip-flop output |
| q_n | output | CHANNELS | Per-channel complement output |
| conflict | output | CHANNELS | Per-channel sticky flag that records preset and clear active together |

## Verification
A corrupted master stage stays hidden during the high phase. It shows up at the ports exactly two system cycles after the device clock input falls, as a wrong `q` on that one edge. A master that fails to clear is seen later, as a spurious change at the next falling edge that follows a quiet high phase. A wrong slave state, or a wrong preset/clear priority, shows up on `q` in the cycle after the synchronized control reaches the slave. The bench therefore compares every channel against a behavioural model on every cycle, and adds directed checks at the exact edge where the latency says each change must appear.

// File: rtl/jkff_pkg.sv
package jkff_pkg;

  // Synchronized per-channel control, active-high.
  typedef struct packed {
    logic dclk;
    logic j;
    logic k;
    logic set;
    logic clr;
  } jk_in_t;

  localparam int JK_IN_W = $bits(jk_in_t);

  // Requests collected by the master during the device-clock high phase.
  typedef struct packed {
    logic jreq;
    logic kreq;
    logic sreq;
    logic rreq;
  } master_t;

  typedef enum logic [1:0] {
    STEER_HOLD = 2'b00,
    STEER_ZERO = 2'b01,
    STEER_ONE  = 2'b10,
    STEER_FLIP = 2'b11
  } steer_e;

  function automatic steer_e decode_steer(input logic j, input logic k);
    steer_e s;
    unique case ({j, k})
      2'b10:   s = STEER_ONE;
      2'b01:   s = STEER_ZERO;
      2'b11:   s = STEER_FLIP;
      default: s = STEER_HOLD;
    endcase
    return s;
  endfunction

  // Output value after a falling edge: clear beats preset, and both beat steering.
  function automatic logic resolve_master(input master_t m, input logic cur);
    logic nxt;
    if (m.rreq)      nxt = 1'b0;
    else if (m.sreq) nxt = 1'b1;
    else begin
      unique case (decode_steer(m.jreq, m.kreq))
        STEER_ONE:  nxt = 1'b1;
        STEER_ZERO: nxt = 1'b0;
        STEER_FLIP: nxt = ~cur;
        default:    nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/jk_sync.sv
module jk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/jk_phase.sv
module jk_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic hi,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign hi   = lvl;
  assign fall = prev & ~lvl;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);                                        // R3
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(hi));                                    // R3
endmodule

// File: rtl/jk_master.sv
module jk_master
  import jkff_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hi,
  input  jk_in_t  cin,
  output master_t mst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= '0;
    end else if (hi) begin
      mst.jreq <= mst.jreq | cin.j;
      mst.kreq <= mst.kreq | cin.k;
      mst.sreq <= mst.sreq | cin.set;
      mst.rreq <= mst.rreq | cin.clr;
    end else begin
      mst <= '0;
    end
  end

  AST_JREQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && $past(hi) && $past(mst.jreq)) |-> mst.jreq);     // R6
  AST_KREQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && $past(hi) && $past(mst.kreq)) |-> mst.kreq);     // R6
  AST_LOW_IGNORES_JK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi && cin.j) |=> !mst.jreq);                          // R5
endmodule

// File: rtl/jk_slave.sv
module jk_slave
  import jkff_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hi,
  input  logic    fall,
  input  jk_in_t  cin,
  input  master_t mst,
  output logic    q,
  output logic    err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (!hi) begin
      if (cin.clr)      q <= 1'b0;
      else if (cin.set) q <= 1'b1;
      else if (fall)    q <= resolve_master(mst, q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  err <= 1'b0;
    else if (cin.set && cin.clr) err <= 1'b1;
  end

  AST_HOLD_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hi |=> $stable(q));                                     // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi && !fall && !cin.set && !cin.clr) |=> $stable(q)); // R3
  AST_DIRECT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi && cin.clr) |=> !q);                               // R7
  AST_DIRECT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi && cin.set && !cin.clr) |=> q);                    // R7
  AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !cin.set && !cin.clr && mst.sreq && !mst.rreq) |=> q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);                                           // R9
endmodule

// File: rtl/dual_msjk_top.sv
module dual_msjk_top
  import jkff_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] dev_clk,
  input  logic [CHANNELS-1:0] j_in,
  input  logic [CHANNELS-1:0] k_in,
  input  logic [CHANNELS-1:0] set_n,
  input  logic [CHANNELS-1:0] clr_n,
  output logic [CHANNELS-1:0] q,
  output logic [CHANNELS-1:0] q_n,
  output logic [CHANNELS-1:0] conflict
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    jk_in_t  raw, syn;
    master_t mst;
    logic    hi, fall;

    assign raw = '{dclk: dev_clk[c], j: j_in[c], k: k_in[c],
                   set: ~set_n[c], clr: ~clr_n[c]};

    jk_sync #(.W(JK_IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    jk_phase u_phase (
      .clk(clk), .rst_n(rst_n), .lvl(syn.dclk), .hi(hi), .fall(fall)
    );

    jk_master u_master (
      .clk(clk), .rst_n(rst_n), .hi(hi), .cin(syn), .mst(mst)
    );

    jk_slave u_slave (
      .clk(clk), .rst_n(rst_n), .hi(hi), .fall(fall), .cin(syn),
      .mst(mst), .q(q[c]), .err(conflict[c])
    );

    assign q_n[c] = ~q[c];
  end
endmodule

// File: tb/dual_msjk_top_tb.sv
module dual_msjk_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0] dev_clk = '0, j_in = '0, k_in = '0;
  logic [CH-1:0] set_n = '1, clr_n = '1;
  logic [CH-1:0] q, q_n, conflict;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string phase_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_msjk_top #(.CHANNELS(CH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_clk(dev_clk), .j_in(j_in), .k_in(k_in),
    .set_n(set_n), .clr_n(clr_n), .q(q), .q_n(q_n), .conflict(conflict)
  );

  // Behavioural reference: inputs take effect two edges after sampling.
  bit [4:0] h1 [CH];
  bit [4:0] h2 [CH];
  bit [4:0] h3 [CH];
  bit m_q [CH];
  bit m_err [CH];
  bit mj [CH];
  bit mk [CH];
  bit ms [CH];
  bit mr [CH];
  bit lvl, fl;

  always @(posedge clk) begin
    for (int c = 0; c < CH; c++) begin
      if (!rst_n) begin
        h1[c] = '0; h2[c] = '0; h3[c] = '0;
        m_q[c] = 0; m_err[c] = 0; mj[c] = 0; mk[c] = 0; ms[c] = 0; mr[c] = 0;
      end else begin
        lvl = h2[c][4];
        fl  = h3[c][4] && !lvl;
        if (h2[c][1] && h2[c][0]) m_err[c] = 1;
        if (lvl) begin
          mj[c] = mj[c] | h2[c][3]; mk[c] = mk[c] | h2[c][2];
          ms[c] = ms[c] | h2[c][1]; mr[c] = mr[c] | h2[c][0];
        end else begin
          if (h2[c][0]) m_q[c] = 0;
          else if (h2[c][1]) m_q[c] = 1;
          else if (fl) begin
            if (mr[c]) m_q[c] = 0;
            else if (ms[c]) m_q[c] = 1;
            else if (mj[c] && mk[c]) m_q[c] = !m_q[c];
            else if (mj[c]) m_q[c] = 1;
            else if (mk[c]) m_q[c] = 0;
          end
          mj[c] = 0; mk[c] = 0; ms[c] = 0; mr[c] = 0;
        end
        h3[c] = h2[c];
        h2[c] = h1[c];
        h1[c] = {dev_clk[c], j_in[c], k_in[c], !set_n[c], !clr_n[c]};
      end
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < CH; c++) begin
        chk(phase_req, "model q", q[c], m_q[c]);
        chk("R2", "q_n complement", q_n[c], ~q[c]);
        chk(phase_req, "model conflict", conflict[c], m_err[c]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dev_pulse(input int c);
    dev_clk[c] = 1'b1; tick(4);
    dev_clk[c] = 1'b0; tick(4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1", "q0 reset", q[0], 0);  chk("R1", "qn0 reset", q_n[0], 1);
    chk("R1", "err0 reset", conflict[0], 0);
    chk("R1", "q1 reset", q[1], 0);

    phase_req = "R4";
    j_in[0] = 1; k_in[0] = 0; dev_pulse(0);
    chk("R4", "J only sets", q[0], 1);
    chk("R10", "ch1 untouched", q[1], 0);
    j_in[0] = 1; k_in[0] = 1; dev_pulse(0);
    chk("R4", "toggle to 0", q[0], 0);
    dev_pulse(0);
    chk("R4", "toggle to 1", q[0], 1);
    j_in[0] = 0; k_in[0] = 0; dev_pulse(0);
    chk("R4", "no steering holds", q[0], 1);
    k_in[0] = 1; dev_pulse(0);
    chk("R4", "K only clears", q[0], 0);

    phase_req = "R5";
    k_in[0] = 0; j_in[0] = 1; tick(6);
    chk("R5", "J while low ignored", q[0], 0);
    j_in[0] = 0; tick(1); dev_pulse(0);
    chk("R5", "no late effect of low-phase J", q[0], 0);

    phase_req = "R6";
    dev_clk[0] = 1; tick(3);
    j_in[0] = 1; tick(1); j_in[0] = 0; tick(3);
    dev_clk[0] = 0; tick(4);
    chk("R6", "one-sample J caught", q[0], 1);

    phase_req = "R3";
    k_in[0] = 1; dev_clk[0] = 1; tick(6);
    chk("R3", "hold during high", q[0], 1);
    dev_clk[0] = 0; tick(2);
    chk("R3", "not yet at E0+1", q[0], 1);
    tick(1);
    chk("R3", "updated at E0+2", q[0], 0);
    k_in[0] = 0; tick(2);

    phase_req = "R7";
    set_n[0] = 0; tick(1); set_n[0] = 1; tick(3);
    chk("R7", "direct preset", q[0], 1);
    clr_n[0] = 0; tick(1); clr_n[0] = 1; tick(3);
    chk("R7", "direct clear", q[0], 0);

    phase_req = "R8";
    dev_clk[0] = 1; tick(3);
    set_n[0] = 0; tick(1); set_n[0] = 1; tick(4);
    chk("R8", "preset in high no immediate effect", q[0], 0);
    dev_clk[0] = 0; tick(4);
    chk("R8", "preset loaded at fall", q[0], 1);
    dev_clk[0] = 1; k_in[0] = 0; j_in[0] = 1; tick(2);
    clr_n[0] = 0; tick(1); clr_n[0] = 1; tick(3);
    dev_clk[0] = 0; tick(1); j_in[0] = 0; tick(3);
    chk("R8", "loaded clear beats J", q[0], 0);

    phase_req = "R9";
    set_n[0] = 1; clr_n[0] = 1; tick(1);
    set_n[0] = 0; clr_n[0] = 0; tick(4);
    chk("R9", "clear wins", q[0], 0);
    chk("R9", "conflict raised", conflict[0], 1);
    set_n[0] = 1; clr_n[0] = 1; tick(6);
    chk("R9", "conflict sticky", conflict[0], 1);
    chk("R10", "ch1 conflict clear", conflict[1], 0);

    phase_req = "R10";
    j_in[1] = 1; dev_pulse(1);
    chk("R10", "ch1 set", q[1], 1);
    chk("R10", "ch0 unaffected", q[0], 0);
    j_in[1] = 0;

    phase_req = "R1";
    @(negedge clk) rst_n = 0; tick(1); rst_n = 1; tick(1);
    chk("R1", "conflict cleared by reset", conflict[0], 0);
    chk("R1", "q1 cleared by reset", q[1], 0);
    tick(2);
    finish_run();
  end
endmodule